// File: doc/BRIEF.md
# Tuner Configuration Register Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (I2C-compatible). It holds the configuration register file of a satellite tuner. It watches the SCL and SDA lines, spots START and STOP, and matches its 7-bit device address. The lowest address bit comes from a strap pin. After the address it takes one byte as the register pointer. In a write, each further byte goes to the register at the pointer, and the pointer then advances. In a read, the pointer is written first. A repeated START with the read bit set then makes the slave shift out registers from the pointer, MSB first, for as long as the master acknowledges.

Twelve configuration registers sit at pointers 0x00 to 0x0B, and each has a fixed reset value. Two read-only status registers follow at 0x0C and 0x0D. Their bits come from outside, except for a power-on flag in bit 7 of 0x0C, which the block keeps itself. A completed write to the divider low byte (0x01) raises a single-cycle trigger that starts the tuner's oscillator band search. The bus lines are sampled through synchronizer flops on a system clock that runs at least 16 times faster than SCL. SDA is only ever pulled low, through an output enable.

The byte engine has seven states:
- IDLE waits for START.
- ADDR receives the address byte.
- PTR receives the pointer byte.
- WDATA receives write data.
- ACK holds SDA low for one bus clock.
- RDATA shifts a register out.
- RACK samples the master's acknowledge.

The transitions are as follows:
- START leads to ADDR from any state, and STOP leads to IDLE from any state.
- ADDR goes to ACK on a matching address, and to IDLE on any other address.
- PTR and WDATA each go to ACK when their byte is complete.
- ACK goes on to PTR, WDATA or RDATA at the falling SCL edge that ends the ninth clock.
- RDATA goes to RACK after its eighth bit.
- RACK goes to RDATA on a master ACK, and to IDLE on a NACK.

Top module: `tuner_i2c_regfile`

## Requirements
- R1: After reset, registers 0x00..0x0B read back as 0x03, 0xB6, 0x00, 0x00, 0x00, 0x04, 0xC0, 0xCC, 0x4B, 0x00, 0x00, 0x00.
- R2: The slave acknowledges the bus byte 0xC0/0xC1 when `addr_strap` is 0 and 0xC2/0xC3 when it is 1. An acknowledge means `sda_oe` is 1 through the high phase of the ninth clock. `sda_oe` only changes while SCL is low.
- R3: For any other address byte the slave gives a NACK. It then ignores the bus, with no acknowledge and no register change, until the next START.
- R4: In a write, the first byte after the address sets the pointer. Each following byte is stored at the pointer and acknowledged, and the pointer then increments.
- R5: A read is a pointer write, a repeated START, then the address with R/W=1. Bytes come out MSB first from successive pointers while the master sends ACK. After a master NACK, `sda_oe` stays 0.
- R6: Writes to pointers 0x0C and above are acknowledged but change nothing. The pointer stops incrementing at 0x0D. Reads at pointers above 0x0D return 0x00.
- R7: Register 0x0C reads as {power-on flag, `stat_flags_i`}, and the flag is 1 after reset. Register 0x0D reads as `stat_band_i`.
- R8: The power-on flag clears only when a transaction that read 0x0C ends with STOP. A read of other registers leaves it set.
- R9: Each completed write to 0x01 gives exactly one single-cycle pulse on `vas_trig_o`. Writes to other registers give none.
- R10: `cfg_flat_o[8k+7:8k]` always shows configuration register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 1 | Device address bit 0 strap (high when unconnected on the board) |
| stat_flags_i | input | 7 | Status bits 6..0 of register 0x0C |
| stat_band_i | input | 8 | Contents of status register 0x0D |
| cfg_flat_o | output | 96 | All twelve configuration registers, register k at bits 8k+7:8k |
| vas_trig_o | output | 1 | One-cycle pulse after a write to register 0x01 |

## Verification
Two actions share one SCL falling edge: the commit of a data byte and the pointer increment, including its clamp at the last status address. A burst write starting at 0x0B runs the pointer across the writable boundary and past the end of the map, so a commit and the clamp land together. The bench then reads back 0x0B, 0x0C, 0x0D and 0x0D again, expecting the stored byte, untouched status and a repeated final register. A STOP that ends a status read and clears the power-on flag is judged by reading 0x0C before and after it.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    // Power-up contents of the writable register file
    function automatic logic [7:0] cfg_reset_value(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h03;
            1:       v = 8'hB6;
            5:       v = 8'h04;
            6:       v = 8'hC0;
            7:       v = 8'hCC;
            8:       v = 8'h4B;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
    import tuner_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_BASE  = 7'h60,
    parameter int unsigned PTR_W     = 8,
    parameter int unsigned LAST_ADDR = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             strap,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             rd_load
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LAST_ADDR);

    bus_state_t       state;
    bus_state_t       nxt;
    logic [2:0]       cnt;
    logic             got8;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic             m_ack;
    logic [6:0]       my_addr;

    assign my_addr = {DEV_BASE[6:1], strap};
    assign rd_addr = ptr;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p < PTR_LAST) ? p + 1'b1 : p;
    endfunction

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            cnt     <= '0;
            got8    <= 1'b0;
            shreg   <= '0;
            ptr     <= '0;
            m_ack   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_load <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_load <= 1'b0;
            if (stop_evt) begin
                state <= ST_IDLE;
            end else if (start_evt) begin
                state <= ST_ADDR;
                cnt   <= '0;
                got8  <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && !got8) begin
                            shreg <= {shreg[6:0], sda_lvl};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == my_addr) begin
                                    nxt   <= shreg[0] ? ST_RDATA : ST_PTR;
                                    state <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr   <= shreg;
                                nxt   <= ST_WDATA;
                                state <= ST_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr_step(ptr);
                                nxt     <= ST_WDATA;
                                state   <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= nxt;
                            if (nxt == ST_RDATA) begin
                                shreg   <= rd_data;
                                rd_load <= 1'b1;
                                cnt     <= '0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            shreg <= {shreg[6:0], 1'b0};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) begin
                                state <= ST_RACK;
                                ptr   <= ptr_step(ptr);
                                cnt   <= '0;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                shreg   <= rd_data;
                                rd_load <= 1'b1;
                                state   <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ACK:   sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~shreg[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    assert_oe_rise_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);
    assert_oe_fall_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_lvl);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    assert_commit_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_ACK));
    assert_ptr_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && ptr == PTR_LAST) |=> (ptr == PTR_LAST || $past(start_evt) || $past(stop_evt)));

endmodule

// File: rtl/tuner_cfg_bank.sv
module tuner_cfg_bank
    import tuner_i2c_pkg::*;
#(
    parameter int unsigned NUM_CFG = 12,
    parameter int unsigned PTR_W   = 8,
    parameter int unsigned TRIG_REG = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [PTR_W-1:0]       rd_addr,
    input  logic                   rd_load,
    input  logic                   start_evt,
    input  logic                   stop_evt,
    input  logic [6:0]             stat_flags,
    input  logic [7:0]             stat_band,
    output logic [7:0]             rd_data,
    output logic [NUM_CFG*8-1:0]   cfg_flat,
    output logic                   vas_trig
);
    localparam int unsigned IW = $clog2(NUM_CFG);
    localparam logic [PTR_W-1:0] STAT_A = PTR_W'(NUM_CFG);
    localparam logic [PTR_W-1:0] STAT_B = PTR_W'(NUM_CFG + 1);
    localparam logic [PTR_W-1:0] TRIG_A = PTR_W'(TRIG_REG);

    logic [7:0] cfg_q [NUM_CFG];
    logic       por;
    logic       stat_seen;

    generate
        for (genvar k = 0; k < NUM_CFG; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cfg_q[k] <= cfg_reset_value(k);
                else if (wr_en && wr_addr == PTR_W'(k))
                    cfg_q[k] <= wr_data;
            end
            assign cfg_flat[k*8 +: 8] = cfg_q[k];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por       <= 1'b1;
            stat_seen <= 1'b0;
            vas_trig  <= 1'b0;
        end else begin
            vas_trig <= wr_en && (wr_addr == TRIG_A);
            if (start_evt)
                stat_seen <= 1'b0;
            else if (rd_load && rd_addr == STAT_A)
                stat_seen <= 1'b1;
            if (stop_evt && stat_seen) begin
                por       <= 1'b0;
                stat_seen <= 1'b0;
            end
        end
    end

    always_comb begin
        if (rd_addr < STAT_A)
            rd_data = cfg_q[rd_addr[IW-1:0]];
        else if (rd_addr == STAT_A)
            rd_data = {por, stat_flags};
        else if (rd_addr == STAT_B)
            rd_data = stat_band;
        else
            rd_data = 8'h00;
    end

    assert_ro_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= STAT_A) |=> $stable(cfg_flat));
    assert_por_needs_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por) |-> $past(stop_evt));
    assert_trig_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vas_trig |=> !vas_trig);

endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile #(
    parameter int unsigned NUM_CFG     = 12,
    parameter int unsigned NUM_STAT    = 2,
    parameter int unsigned PTR_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_BASE    = 7'h60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic                 addr_strap,
    input  logic [6:0]           stat_flags_i,
    input  logic [7:0]           stat_band_i,
    output logic [NUM_CFG*8-1:0] cfg_flat_o,
    output logic                 vas_trig_o
);
    localparam int unsigned LAST_ADDR = NUM_CFG + NUM_STAT - 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic             wr_en, rd_load;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    tuner_i2c_engine #(
        .DEV_BASE  (DEV_BASE),
        .PTR_W     (PTR_W),
        .LAST_ADDR (LAST_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap     (addr_strap),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_load   (rd_load)
    );

    tuner_cfg_bank #(
        .NUM_CFG  (NUM_CFG),
        .PTR_W    (PTR_W),
        .TRIG_REG (1)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_load    (rd_load),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .stat_flags (stat_flags_i),
        .stat_band  (stat_band_i),
        .rd_data    (rd_data),
        .cfg_flat   (cfg_flat_o),
        .vas_trig   (vas_trig_o)
    );

endmodule

// File: tb/tuner_i2c_regfile_test.sv
module tuner_i2c_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        strap = 1'b1;
    logic [6:0]  sflags = 7'h2A;
    logic [7:0]  sband = 8'h5C;
    logic        sda_oe;
    logic [95:0] cfg_flat;
    logic        vas_trig;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int trig_cnt = 0;
    logic       por_exp = 1'b1;
    logic [7:0] exp_cfg [12];
    logic [7:0] rbuf [14];

    always #2.5 clk = ~clk;

    tuner_i2c_regfile uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .addr_strap   (strap),
        .stat_flags_i (sflags),
        .stat_band_i  (sband),
        .cfg_flat_o   (cfg_flat),
        .vas_trig_o   (vas_trig)
    );

    always @(negedge clk) if (vas_trig) trig_cnt++;

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input int a);
        if (a < 12) return exp_cfg[a];
        if (a == 12) return {por_exp, sflags};
        if (a == 13) return sband;
        return 8'h00;
    endfunction

    task automatic chk_cfg(input string tag);
        for (int k = 0; k < 12; k++)
            chk(tag, {24'h0, cfg_flat[k*8 +: 8]}, {24'h0, exp_cfg[k]});
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
    endtask

    task automatic bstop();
        sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
        end
        sda_m = 1'b1; q(); scl = 1'b1; q();
        acked = (sda_line == 1'b0);
        q(); scl = 1'b0; q();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
        end
        q(); sda_m = ~mack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sda_m = 1'b1;
    endtask

    // write n bytes starting at pointer p; returns number of acks seen
    task automatic wr_burst(input logic [7:0] dev, input logic [7:0] p, input int n,
                            input logic [31:0] d, output int acks);
        bit a;
        acks = 0;
        bstart();
        send_byte(dev & 8'hFE, a); acks += int'(a);
        send_byte(p, a); acks += int'(a);
        for (int i = 0; i < n; i++) begin
            send_byte(d[31-8*i -: 8], a); acks += int'(a);
        end
        bstop();
    endtask

    task automatic rd_burst(input logic [7:0] dev, input logic [7:0] p, input int n, input bit end_stop);
        bit a;
        logic [7:0] v;
        bstart();
        send_byte(dev & 8'hFE, a);
        send_byte(p, a);
        bstart();
        send_byte(dev | 8'h01, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            rbuf[i] = v;
        end
        if (end_stop) bstop();
    endtask

    task automatic t_reset();
        chk("R10 sda_oe after reset", {31'h0, sda_oe}, 32'h0);
        chk_cfg("R1 R10 reset outputs");
    endtask

    task automatic t_read_defaults();
        rd_burst(8'hC2, 8'h00, 12, 1'b1);
        for (int i = 0; i < 12; i++)
            chk("R1 R5 burst readback", {24'h0, rbuf[i]}, {24'h0, model_read(i)});
    endtask

    task automatic t_status_por();
        rd_burst(8'hC2, 8'h0D, 1, 1'b1);
        chk("R7 band status", {24'h0, rbuf[0]}, {24'h0, sband});
        rd_burst(8'hC2, 8'h0C, 1, 1'b1);
        chk("R7 R8 flag still set", {24'h0, rbuf[0]}, {24'h0, 1'b1, sflags});
        por_exp = 1'b0;
        rd_burst(8'hC2, 8'h0C, 1, 1'b1);
        chk("R8 flag cleared after STOP", {24'h0, rbuf[0]}, {24'h0, 1'b0, sflags});
    endtask

    task automatic t_write_trig();
        int acks;
        int t0;
        t0 = trig_cnt;
        wr_burst(8'hC2, 8'h00, 2, 32'h1234_0000, acks);
        exp_cfg[0] = 8'h12; exp_cfg[1] = 8'h34;
        chk("R4 write acks", acks, 4);
        chk_cfg("R4 R10 burst write");
        chk("R9 one pulse for divider low byte", trig_cnt - t0, 1);
        t0 = trig_cnt;
        wr_burst(8'hC2, 8'h08, 1, 32'h5A00_0000, acks);
        exp_cfg[8] = 8'h5A;
        chk_cfg("R4 single write");
        chk("R9 no pulse for other register", trig_cnt - t0, 0);
    endtask

    task automatic t_address();
        int acks;
        wr_burst(8'hA0, 8'h02, 1, 32'h7700_0000, acks);
        chk("R3 wrong address no acks", acks, 0);
        chk_cfg("R3 wrong address ignored");
        strap = 1'b0;
        wr_burst(8'hC2, 8'h02, 1, 32'h6600_0000, acks);
        chk("R2 strap low rejects C2", acks, 0);
        chk_cfg("R2 strap low rejects C2 data");
        wr_burst(8'hC0, 8'h02, 1, 32'h6600_0000, acks);
        exp_cfg[2] = 8'h66;
        chk("R2 strap low accepts C0", acks, 3);
        chk_cfg("R2 strap low write");
        rd_burst(8'hC0, 8'h02, 1, 1'b1);
        chk("R2 R5 read at C1", {24'h0, rbuf[0]}, 32'h66);
        strap = 1'b1;
    endtask

    task automatic t_boundary();
        int acks;
        wr_burst(8'hC2, 8'h0B, 4, 32'h55AA_7799, acks);
        exp_cfg[11] = 8'h55;
        chk("R6 all boundary bytes acked", acks, 6);
        chk_cfg("R6 read-only writes discarded");
        rd_burst(8'hC2, 8'h0B, 4, 1'b1);
        chk("R6 byte at 0x0B", {24'h0, rbuf[0]}, 32'h55);
        chk("R6 R7 status 0x0C intact", {24'h0, rbuf[1]}, {24'h0, model_read(12)});
        chk("R6 R7 status 0x0D intact", {24'h0, rbuf[2]}, {24'h0, sband});
        chk("R6 pointer clamps at 0x0D", {24'h0, rbuf[3]}, {24'h0, sband});
        rd_burst(8'hC2, 8'h20, 1, 1'b1);
        chk("R6 unmapped read zero", {24'h0, rbuf[0]}, 32'h0);
    endtask

    task automatic t_nack_end();
        rd_burst(8'hC2, 8'h0D, 1, 1'b0);
        q(); q(); q();
        chk("R5 released after master NACK", {31'h0, sda_oe}, 32'h0);
        scl = 1'b1; q();
        chk("R5 released while SCL high", {31'h0, sda_oe}, 32'h0);
        sda_m = 1'b0; q(); scl = 1'b0; q();
        bstop();
        chk("R5 value before NACK", {24'h0, rbuf[0]}, {24'h0, sband});
    endtask

    initial begin
        for (int k = 0; k < 12; k++) exp_cfg[k] = 8'h00;
        exp_cfg[0] = 8'h03; exp_cfg[1] = 8'hB6; exp_cfg[5] = 8'h04;
        exp_cfg[6] = 8'hC0; exp_cfg[7] = 8'hCC; exp_cfg[8] = 8'h4B;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read_defaults();
        t_status_por();
        t_write_trig();
        t_address();
        t_boundary();
        t_nack_end();
        report();
        $finish;
    end

endmodule